// File: doc/BRIEF.md
# Calendar time register block

This block keeps wall-clock time as seconds, minutes and hours, plus a calendar date made of day, month, a six-bit year offset and a leap flag. The leap flag is set by software. The count moves forward by one second on each cycle in which the one-second `tick` input is high. Carries ripple up through minutes, hours, days, months and years.

Software reaches two packed registers over a simple word-addressed bus: one for time and one for date. A write is not applied at once. The value is held as pending, and it lands in the counting registers after a fixed number of clock cycles. During that interval a per-register busy bit in the control word reads as one. Software waits for the busy bits to read zero before it writes again. To get a consistent snapshot, it reads time and date twice and keeps the pair that matches both times.

The year field is an offset from 1970 and covers 1970 through 2033. The leap flag does not change on its own: the counter only reads it to size February.

Top module: `rtc_calendar`

## Requirements
- R1: The time word (addr 1) holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16, with all other bits zero. After reset it reads 0x00000000.
- R2: The date word (addr 2) holds day in bits 4:0, month in bits 11:8, the year offset from 1970 in bits 21:16 and the leap flag in bit 22, with other bits zero. After reset it reads 0x00000101, which is day 1 of month 1 at offset 0.
- R3: Each cycle with `tick` high adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R4: When the day carry arrives on the last day of the month, the day becomes 1 and the month advances. Months 4, 6, 9 and 11 end on day 30. Month 2 ends on day 28, or on day 29 when the leap flag is 1. All other months end on day 31.
- R5: A month carry out of month 12 gives month 1 and adds one to the year. Year offset 63 wraps to 0. The leap flag keeps its value across the year change.
- R6: A write to the time word sets control bit 8, and a write to the date word sets control bit 7. Control is at addr 0. The bit reads one for COMMIT_CYC cycles after the write edge. The written value appears in its register on the same edge at which the bit clears.
- R7: A write to the time or date word while that word's own busy bit is set is ignored. The value committed is that of the first write.
- R8: Control bit 9, the alarm busy bit, always reads zero. With no commit pending, bits 9:7 read zero. Writes to addr 0 change nothing.
- R9: Ticks that arrive while a time write is pending advance the old time. The commit then replaces it with the written value exactly.
- R10: A read with `rd_en` high captures the addressed word into `rdata` on the next clock edge. Addr 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 control, 1 time, 2 date |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |

## Verification
The assertions check on every cycle that a tick with no commit pending steps or wraps the seconds field correctly. They also check that time and date hold still when there is neither a tick nor a commit, that a busy bit lasts more than one cycle, and that a write while busy leaves the pending value alone. Only the bench's scenarios show the rest. These are the month-length and leap-year day rollovers, the month and year wrap with the leap flag held, the exact read timing of the busy bits against the commit, and a pending commit overriding ticks that arrived in the meantime.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int COMMIT_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int CW = $clog2(COMMIT_CYC + 1);

  logic [5:0] sec, mins;
  logic [4:0] hr, day;
  logic [3:0] mon;
  logic [5:0] yr;
  logic       leap;
  logic [31:0] t_pend, d_pend;
  logic [CW-1:0] t_cnt, d_cnt;
  logic [4:0] mlen;

  wire t_busy   = t_cnt != '0;
  wire d_busy   = d_cnt != '0;
  wire t_commit = t_cnt == CW'(1);
  wire d_commit = d_cnt == CW'(1);

  wire sec_wrap = sec == 6'd59;
  wire min_wrap = sec_wrap && mins == 6'd59;
  wire hr_wrap  = min_wrap && hr == 5'd23;
  wire day_wrap = hr_wrap && day >= mlen;
  wire mon_wrap = day_wrap && mon >= 4'd12;

  wire [31:0] time_word = {11'd0, hr, 2'd0, mins, 2'd0, sec};
  wire [31:0] date_word = {9'd0, leap, yr, 4'd0, mon, 3'd0, day};
  wire [31:0] ctrl_word = {22'd0, 1'b0, t_busy, d_busy, 7'd0};

  logic unused_bits;
  assign unused_bits = ^{t_pend[31:21], t_pend[15:14], t_pend[7:6],
                         d_pend[31:23], d_pend[15:12], d_pend[7:5]};

  always_comb begin
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: mlen = 5'd30;
      4'd2:                    mlen = leap ? 5'd29 : 5'd28;
      default:                 mlen = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_cnt  <= '0;
      d_cnt  <= '0;
      t_pend <= '0;
      d_pend <= '0;
    end else begin
      if (wr_en && addr == 2'd1 && !t_busy) begin
        t_cnt  <= CW'(COMMIT_CYC);
        t_pend <= wdata;
      end else if (t_busy) begin
        t_cnt <= t_cnt - CW'(1);
      end
      if (wr_en && addr == 2'd2 && !d_busy) begin
        d_cnt  <= CW'(COMMIT_CYC);
        d_pend <= wdata;
      end else if (d_busy) begin
        d_cnt <= d_cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= '0;
      mins <= '0;
      hr   <= '0;
    end else if (t_commit) begin
      sec  <= t_pend[5:0];
      mins <= t_pend[13:8];
      hr   <= t_pend[20:16];
    end else if (tick) begin
      sec <= sec_wrap ? 6'd0 : sec + 6'd1;
      if (sec_wrap) mins <= min_wrap ? 6'd0 : mins + 6'd1;
      if (min_wrap) hr   <= hr_wrap  ? 5'd0 : hr + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day  <= 5'd1;
      mon  <= 4'd1;
      yr   <= '0;
      leap <= 1'b0;
    end else if (d_commit) begin
      day  <= d_pend[4:0];
      mon  <= d_pend[11:8];
      yr   <= d_pend[21:16];
      leap <= d_pend[22];
    end else if (tick && hr_wrap && !t_commit) begin
      day <= day_wrap ? 5'd1 : day + 5'd1;
      if (day_wrap) mon <= mon_wrap ? 4'd1 : mon + 4'd1;
      if (mon_wrap) yr  <= yr + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        2'd0:    rdata <= ctrl_word;
        2'd1:    rdata <= time_word;
        2'd2:    rdata <= date_word;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int COMMIT_CYC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [31:0] time_word,
  input logic [31:0] date_word,
  input logic [31:0] t_pend,
  input logic        t_busy,
  input logic        d_busy
);
  wire [5:0] s = time_word[5:0];

  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !t_busy && s != 6'd59 |=> time_word[5:0] == $past(s) + 6'd1);

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !t_busy && s == 6'd59 |=> time_word[5:0] == 6'd0);

  p_time_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !t_busy |=> $stable(time_word));

  p_date_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !d_busy |=> $stable(date_word));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    t_busy && wr_en && addr == 2'd1 |=> $stable(t_pend));

  generate
    if (COMMIT_CYC > 1) begin : g_len
      p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_busy) |=> t_busy);
    end
  endgenerate
endmodule

bind rtc_calendar rtc_calendar_chk #(.COMMIT_CYC(COMMIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .time_word(time_word), .date_word(date_word), .t_pend(t_pend),
  .t_busy(t_busy), .d_busy(d_busy)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.COMMIT_CYC(2)) u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  // {time_in, date_in, time_exp, date_exp} after one tick
  localparam logic [127:0] VEC [13] = '{
    {32'h00000000, 32'h00000101, 32'h00000001, 32'h00000101},
    {32'h0000003B, 32'h00000101, 32'h00000100, 32'h00000101},
    {32'h00003B3B, 32'h00000101, 32'h00010000, 32'h00000101},
    {32'h00173B3B, 32'h0000050F, 32'h00000000, 32'h00000510},
    {32'h00173B3B, 32'h0000041E, 32'h00000000, 32'h00000501},
    {32'h00173B3B, 32'h0000011F, 32'h00000000, 32'h00000201},
    {32'h00173B3B, 32'h0000021C, 32'h00000000, 32'h00000301},
    {32'h00173B3B, 32'h0040021C, 32'h00000000, 32'h0040021D},
    {32'h00173B3B, 32'h0040021D, 32'h00000000, 32'h00400301},
    {32'h00173B3B, 32'h00050C1F, 32'h00000000, 32'h00060101},
    {32'h00173B3B, 32'h007F0C1F, 32'h00000000, 32'h00400101},
    {32'h00173B3B, 32'h00000B1E, 32'h00000000, 32'h00000C01},
    {32'h000C2238, 32'h0000060A, 32'h000C2239, 32'h0000060A}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic pulse();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    rd(2'd1, v); chk("R1 reset time", v, 32'h0);
    rd(2'd2, v); chk("R2 reset date", v, 32'h00000101);
    rd(2'd0, v); chk("R8 reset ctrl", v, 32'h0);

    for (int i = 0; i < 13; i++) begin
      wr(2'd1, VEC[i][127:96]);
      wr(2'd2, VEC[i][95:64]);
      idle(3);
      pulse();
      rd(2'd1, v); chk($sformatf("R3 R4 R5 vec %0d time", i), v, VEC[i][63:32]);
      rd(2'd2, v); chk($sformatf("R4 R5 vec %0d date", i), v, VEC[i][31:0]);
    end

    // R6 busy timing, time word
    wr(2'd1, 32'h00050607);
    rd(2'd0, v); chk("R6 time busy 1", v, 32'h00000100);
    rd(2'd0, v); chk("R6 time busy 2", v, 32'h00000100);
    rd(2'd0, v); chk("R6 time busy clear", v, 32'h0);
    rd(2'd1, v); chk("R6 time committed", v, 32'h00050607);

    // R6 busy timing, date word
    wr(2'd2, 32'h00030405);
    rd(2'd0, v); chk("R6 date busy", v, 32'h00000080);
    rd(2'd0, v); chk("R6 date busy 2", v, 32'h00000080);
    rd(2'd0, v); chk("R6 date busy clear", v, 32'h0);
    rd(2'd2, v); chk("R6 date committed", v, 32'h00030405);

    // R7 second write while busy is ignored
    wr(2'd1, 32'h00010101);
    wr(2'd1, 32'h00020202);
    idle(3);
    rd(2'd1, v); chk("R7 time ignore", v, 32'h00010101);
    wr(2'd2, 32'h00000703);
    wr(2'd2, 32'h00000809);
    idle(3);
    rd(2'd2, v); chk("R7 date ignore", v, 32'h00000703);

    // R8 control writes change nothing
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, v); chk("R8 ctrl write ignored", v, 32'h0);
    rd(2'd1, v); chk("R8 time untouched", v, 32'h00010101);
    rd(2'd2, v); chk("R8 date untouched", v, 32'h00000703);

    // R9 ticks during pending commit are overwritten
    wr(2'd1, 32'h00040506);
    pulse();
    idle(2);
    rd(2'd1, v); chk("R9 commit wins", v, 32'h00040506);

    // R3 several ticks in a row
    pulse(); pulse(); pulse(); pulse(); pulse();
    rd(2'd1, v); chk("R3 five ticks", v, 32'h0004050B);

    // R10 unmapped address
    rd(2'd3, v); chk("R10 addr 3 zero", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule